// File: doc/BRIEF.md
# Data-Enable Video Timing Recovery

This block rebuilds line and frame structure from a pixel stream in which the only qualifier is a data-enable level. No horizontal or vertical sync enters the block. The length of each data-enable-low run decides what it means. A short run is a pause inside a line. A medium run separates two lines. A long run separates two frames. Blanking has no upper bound and may change from one frame to the next. Each decision is taken on the clock edge where data-enable returns high, so the close of a line and the close of a frame are both known together with the first pixel that follows them.

At every frame boundary the block reports the frame it has just finished. It gives the number of lines, the widest line, and a vertical scale decision. The frame is accepted only when its line count equals the base height divided by 1, 2, 3 or 4. By default the accepted counts are 2160, 1080, 720 and 540. Any other count raises a format-invalid flag, and a display pipeline uses that flag to substitute a warning image. An over-wide line only raises a warning. Pixel data and data-enable pass through with a single register stage whatever the flags say.

Top module: `de_timing_recover`

## Requirements
- R1: Synchronous active-low reset clears every output: data-enable out, pixel out, both strobes, frame-done, line and width counts, valid, invalid, scale ratio and wide warning.
- R2: `de_o` and `pix_o` equal `de_i` and `pix_i` one cycle later, whether or not the frame is invalid or over-wide.
- R3: When `de_i` goes high after at least LINE_GAP+1 (9) consecutive low clocks, `sol_o` is high in the following cycle.
- R4: A low run of LINE_GAP (8) clocks or fewer inside a line does not start a new line. `sol_o` stays low, and the pixels on both sides of the pause count as one line.
- R5: When `de_i` goes high after at least FRAME_GAP+1 (511) consecutive low clocks, `sof_o` and `sol_o` are both high in the following cycle. After exactly 510 low clocks only `sol_o` rises, and the lines on both sides belong to one frame.
- R6: Blanking of any length, and of different lengths from frame to frame, produces exactly one frame boundary with correct counts.
- R7: At a frame boundary, `frame_done_o` pulses in the same cycle as `sof_o`. In that cycle `frame_lines_o` holds the number of lines in the closed frame, its last line included, and `frame_width_o` holds the pixel count of its widest line.
- R8: The first frame boundary after reset still raises `sof_o`. It does not raise `frame_done_o`, so the frame that was in progress at reset is never reported.
- R9: If the line count equals BASE_LINES/k for a k from 1 to 4, then `fmt_valid_o` is 1, `fmt_invalid_o` is 0 and `ratio_o` equals k.
- R10: Any other line count gives `fmt_invalid_o` equal to 1, `fmt_valid_o` equal to 0 and `ratio_o` equal to 0.
- R11: `wide_o` is 1 exactly when the widest line of the reported frame has more than MAX_WIDTH pixels.
- R12: The reported counts and flags stay unchanged from one `frame_done_o` pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| de_i | input | 1 | Data-enable qualifier |
| pix_i | input | PIX_W | Pixel data |
| de_o | output | 1 | Data-enable, delayed one cycle |
| pix_o | output | PIX_W | Pixel data, delayed one cycle |
| sol_o | output | 1 | First pixel of a line, aligned with `de_o` |
| sof_o | output | 1 | First pixel of a frame, aligned with `de_o` |
| frame_done_o | output | 1 | One-cycle pulse when results of a frame are latched |
| frame_lines_o | output | LINE_CW | Line count of the last reported frame |
| frame_width_o | output | PIX_CW | Widest line of the last reported frame |
| fmt_valid_o | output | 1 | Line count matches a supported ratio |
| fmt_invalid_o | output | 1 | Line count matches no supported ratio |
| ratio_o | output | RATIO_W | Vertical divisor 1..4, or 0 when invalid |
| wide_o | output | 1 | Widest line exceeds MAX_WIDTH |

## Verification
The close of the last line of a frame, the close of the frame, and the opening of the next frame all happen on one clock edge. That edge is the first high data-enable after the long gap. The count that is latched must therefore include a line that has only just been closed, while the counters restart for the new frame. The bench runs frames back to back with blanking of exactly 511, 510 and much longer. At the first pixel of every frame it compares `sof_o`, `sol_o`, `frame_done_o` and the latched results against a model that accumulates lines and widths in the bench. A 510-clock gap must merge two frames into one report.

// File: rtl/dtr_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the data-enable timing recovery block.
// Assumes: callers pass positive limits.
package dtr_pkg;

    // Width of a counter that must hold values above `limit` so it can saturate past it.
    function automatic int sat_width(input int limit);
        return $clog2(limit + 1) + 1;
    endfunction

    // Width needed to encode 0..n.
    function automatic int code_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dtr_gap_track.sv
`timescale 1ns/1ps
// Counts consecutive data-enable-low clocks and classifies the gap when
// data-enable returns high: line break (> LINE_GAP) or frame break (> FRAME_GAP).
// Assumes: LINE_GAP < FRAME_GAP; GAP_CW can hold FRAME_GAP + 1.
module dtr_gap_track #(
    parameter int LINE_GAP  = 8,
    parameter int FRAME_GAP = 510,
    parameter int GAP_CW    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic de_i,
    output logic line_brk_o,
    output logic frame_brk_o
);

    localparam int SAT = FRAME_GAP + 1;

    logic [GAP_CW-1:0] gap_q;

    // Low-run counter; cleared by any active pixel, holds once above FRAME_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (de_i) begin
            gap_q <= '0;
        end else if (gap_q != GAP_CW'(SAT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Gap classification, valid only on the first active pixel after the gap.
    assign line_brk_o  = de_i && (gap_q > GAP_CW'(LINE_GAP));
    assign frame_brk_o = de_i && (gap_q > GAP_CW'(FRAME_GAP));

    // R6
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_CW'(SAT));

    // R5
    frame_implies_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_brk_o |-> line_brk_o);

    // R6
    gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_i |=> gap_q == '0);

endmodule

// File: rtl/dtr_line_count.sv
`timescale 1ns/1ps
// Counts pixels per line, lines per frame and the widest line of the frame.
// Exposes the totals including a line being closed this cycle, so a frame
// break can latch them on the same edge that restarts the counters.
// Assumes: line_brk_i and frame_brk_i are only high with de_i high.
module dtr_line_count #(
    parameter int PIX_CW  = 13,
    parameter int LINE_CW = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               de_i,
    input  logic               line_brk_i,
    input  logic               frame_brk_i,
    output logic [LINE_CW-1:0] lines_total_o,
    output logic [PIX_CW-1:0]  widest_total_o
);

    logic [PIX_CW-1:0]  pix_q;
    logic [LINE_CW-1:0] line_q;
    logic [PIX_CW-1:0]  widest_q;
    logic               closing;

    // A line closes only if it actually held pixels.
    assign closing = line_brk_i && (pix_q != '0);

    // Totals seen by the frame latch, counting the line that closes now.
    always_comb begin
        lines_total_o  = line_q;
        widest_total_o = widest_q;
        if (closing) begin
            if (!(&line_q)) lines_total_o = line_q + 1'b1;
            if (pix_q > widest_q) widest_total_o = pix_q;
        end
    end

    // Counter update on each active pixel; idle cycles leave everything held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q    <= '0;
            line_q   <= '0;
            widest_q <= '0;
        end else if (de_i) begin
            if (frame_brk_i) begin
                line_q   <= '0;
                widest_q <= '0;
                pix_q    <= PIX_CW'(1);
            end else if (line_brk_i) begin
                line_q   <= lines_total_o;
                widest_q <= widest_total_o;
                pix_q    <= PIX_CW'(1);
            end else if (!(&pix_q)) begin
                pix_q <= pix_q + 1'b1;
            end
        end
    end

    // R4
    pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |=> $stable(pix_q));

    // R3
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_brk_i |=> pix_q == PIX_CW'(1));

    // R7
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_brk_i |=> (line_q == '0) && (widest_q == '0));

endmodule

// File: rtl/dtr_scale_check.sv
`timescale 1ns/1ps
// Maps a frame line count onto an integer vertical divisor 1..NUM_RATIOS.
// A count matches divisor k when it equals BASE_LINES / k; otherwise 0.
// Assumes: BASE_LINES / k are distinct for k = 1..NUM_RATIOS.
module dtr_scale_check #(
    parameter int BASE_LINES = 2160,
    parameter int NUM_RATIOS = 4,
    parameter int LINE_CW    = 13,
    parameter int RATIO_W    = 3
) (
    input  logic               rst_n,
    input  logic [LINE_CW-1:0] lines_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               valid_o
);

    logic [NUM_RATIOS-1:0] hit;

    // One exact comparator per supported divisor.
    for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_ratio
        assign hit[k] = (lines_i == LINE_CW'(BASE_LINES / (k + 1)));
    end

    // Encode the matching divisor; zero when nothing matches.
    always_comb begin
        ratio_o = '0;
        for (int k = 0; k < NUM_RATIOS; k++) begin
            if (hit[k]) ratio_o = RATIO_W'(k + 1);
        end
    end

    assign valid_o = |hit;

    // R9
    always_comb begin
        if (rst_n) begin
            one_ratio_chk: assert ($onehot0(hit));
        end
    end

endmodule

// File: rtl/de_timing_recover.sv
`timescale 1ns/1ps
// Top of the data-enable timing recovery block. Classifies data-enable-low
// gaps, emits start-of-line / start-of-frame strobes aligned with the delayed
// pixel stream, and latches per-frame line count, widest line, scale decision
// and width warning at each frame boundary after the first.
// Assumes: a continuous pixel clock; sync signals are not used.
module de_timing_recover
    import dtr_pkg::*;
#(
    parameter int PIX_W      = 24,
    parameter int BASE_LINES = 2160,
    parameter int NUM_RATIOS = 4,
    parameter int MAX_WIDTH  = 3840,
    parameter int LINE_GAP   = 8,
    parameter int FRAME_GAP  = 510,
    localparam int LINE_CW   = sat_width(BASE_LINES),
    localparam int PIX_CW    = sat_width(MAX_WIDTH),
    localparam int RATIO_W   = code_width(NUM_RATIOS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               de_i,
    input  logic [PIX_W-1:0]   pix_i,
    output logic               de_o,
    output logic [PIX_W-1:0]   pix_o,
    output logic               sol_o,
    output logic               sof_o,
    output logic               frame_done_o,
    output logic [LINE_CW-1:0] frame_lines_o,
    output logic [PIX_CW-1:0]  frame_width_o,
    output logic               fmt_valid_o,
    output logic               fmt_invalid_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               wide_o
);

    localparam int GAP_CW = $clog2(FRAME_GAP + 2);

    logic               line_brk;
    logic               frame_brk;
    logic [LINE_CW-1:0] lines_total;
    logic [PIX_CW-1:0]  widest_total;
    logic [RATIO_W-1:0] ratio_d;
    logic               valid_d;
    logic               armed_q;

    dtr_gap_track #(
        .LINE_GAP  (LINE_GAP),
        .FRAME_GAP (FRAME_GAP),
        .GAP_CW    (GAP_CW)
    ) u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .de_i        (de_i),
        .line_brk_o  (line_brk),
        .frame_brk_o (frame_brk)
    );

    dtr_line_count #(
        .PIX_CW  (PIX_CW),
        .LINE_CW (LINE_CW)
    ) u_count (
        .clk            (clk),
        .rst_n          (rst_n),
        .de_i           (de_i),
        .line_brk_i     (line_brk),
        .frame_brk_i    (frame_brk),
        .lines_total_o  (lines_total),
        .widest_total_o (widest_total)
    );

    dtr_scale_check #(
        .BASE_LINES (BASE_LINES),
        .NUM_RATIOS (NUM_RATIOS),
        .LINE_CW    (LINE_CW),
        .RATIO_W    (RATIO_W)
    ) u_scale (
        .rst_n   (rst_n),
        .lines_i (lines_total),
        .ratio_o (ratio_d),
        .valid_o (valid_d)
    );

    // Pass-through stage and strobes, all aligned one cycle after the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_o         <= 1'b0;
            pix_o        <= '0;
            sol_o        <= 1'b0;
            sof_o        <= 1'b0;
            frame_done_o <= 1'b0;
        end else begin
            de_o         <= de_i;
            pix_o        <= pix_i;
            sol_o        <= line_brk;
            sof_o        <= frame_brk;
            frame_done_o <= frame_brk && armed_q;
        end
    end

    // Frame result latch; the first boundary after reset only arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q       <= 1'b0;
            frame_lines_o <= '0;
            frame_width_o <= '0;
            fmt_valid_o   <= 1'b0;
            fmt_invalid_o <= 1'b0;
            ratio_o       <= '0;
            wide_o        <= 1'b0;
        end else if (frame_brk) begin
            armed_q <= 1'b1;
            if (armed_q) begin
                frame_lines_o <= lines_total;
                frame_width_o <= widest_total;
                fmt_valid_o   <= valid_d;
                fmt_invalid_o <= !valid_d;
                ratio_o       <= ratio_d;
                wide_o        <= (widest_total > PIX_CW'(MAX_WIDTH));
            end
        end
    end

    // R7
    done_with_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> sof_o);

    // R5
    sof_with_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> sol_o);

    // R12
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done_o |-> $stable(frame_lines_o) && $stable(ratio_o) && $stable(wide_o));

    // R10
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fmt_valid_o && fmt_invalid_o));

endmodule

// File: tb/de_timing_recover_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of frames, then directed tests for
// frame merging at a 510-clock gap and for reset in the middle of a stream.
module de_timing_recover_bench;

    localparam int PIX_W   = 24;
    localparam int BASE    = 24;
    localparam int MAXW    = 16;
    localparam int LINE_CW = $clog2(BASE + 1) + 1;
    localparam int PIX_CW  = $clog2(MAXW + 1) + 1;
    localparam int RATIO_W = $clog2(5);
    localparam int NVEC    = 8;

    // Columns: lines, width, wide first line (0 = none), split line 1, blanking, expected ratio
    localparam int VEC [NVEC][6] = '{
        '{24, 16,  0, 0,  520, 1},
        '{12, 10,  0, 1,  600, 2},
        '{ 8, 16, 17, 0,  511, 3},
        '{ 6,  5,  0, 0, 2000, 4},
        '{ 7,  8,  0, 0,  530, 0},
        '{25,  4,  0, 0,  515, 0},
        '{23,  4,  0, 1,  700, 0},
        '{ 1,  3,  0, 0,  511, 0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               de_i = 1'b0;
    logic [PIX_W-1:0]   pix_i = '0;
    logic               de_o;
    logic [PIX_W-1:0]   pix_o;
    logic               sol_o;
    logic               sof_o;
    logic               frame_done_o;
    logic [LINE_CW-1:0] frame_lines_o;
    logic [PIX_CW-1:0]  frame_width_o;
    logic               fmt_valid_o;
    logic               fmt_invalid_o;
    logic [RATIO_W-1:0] ratio_o;
    logic               wide_o;

    int n_chk = 0;
    int n_fail = 0;
    int prev_gap = 0;
    int acc_lines = 0;
    int acc_w = 0;
    int pend_r = 0;
    int last_lines = 0;
    int pcount = 1;
    bit armed = 1'b0;
    bit have_latched = 1'b0;

    always #2.5 clk = ~clk;

    de_timing_recover #(
        .PIX_W      (PIX_W),
        .BASE_LINES (BASE),
        .MAX_WIDTH  (MAXW)
    ) u_de_timing_recover (
        .clk           (clk),
        .rst_n         (rst_n),
        .de_i          (de_i),
        .pix_i         (pix_i),
        .de_o          (de_o),
        .pix_o         (pix_o),
        .sol_o         (sol_o),
        .sof_o         (sof_o),
        .frame_done_o  (frame_done_o),
        .frame_lines_o (frame_lines_o),
        .frame_width_o (frame_width_o),
        .fmt_valid_o   (fmt_valid_o),
        .fmt_invalid_o (fmt_invalid_o),
        .ratio_o       (ratio_o),
        .wide_o        (wide_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic d, input int p);
        @(negedge clk);
        de_i  = d;
        pix_i = PIX_W'(p);
    endtask

    task automatic check_idle_outputs(input string tag);
        chk(de_o == 1'b0 && pix_o == '0, tag, "pass-through cleared", int'(de_o), 0);
        chk(sol_o == 1'b0 && sof_o == 1'b0, tag, "strobes cleared", int'(sol_o), 0);
        chk(frame_done_o == 1'b0, tag, "frame_done cleared", int'(frame_done_o), 0);
        chk(frame_lines_o == '0 && frame_width_o == '0, tag, "counts cleared", int'(frame_lines_o), 0);
        chk(!fmt_valid_o && !fmt_invalid_o && ratio_o == '0 && !wide_o, tag, "flags cleared",
            int'(ratio_o), 0);
    endtask

    // Send one frame; the first pixel checks the boundary that precedes it.
    task automatic run_frame(input int nl, input int w, input int wide_w,
                             input int split, input int vb, input int exp_r);
        int pv;
        int lw;
        bit bnd;
        for (int ln = 0; ln < nl; ln++) begin
            lw = (ln == 0 && wide_w > 0) ? wide_w : w;
            for (int px = 0; px < lw; px++) begin
                if (split != 0 && ln == 1 && px == lw / 2) begin
                    repeat (8) tick(1'b0, 0);
                end
                pv = pcount;
                pcount++;
                tick(1'b1, pv);
                if (px == 0 && ln == 0) begin
                    @(posedge clk);
                    #1;
                    bnd = (prev_gap > 510);
                    // R2 pixel and enable delayed by one register
                    chk(de_o == 1'b1 && pix_o == PIX_W'(pv), "R2", "pass-through pixel",
                        int'(pix_o), pv);
                    // R3 line opened after a gap of nine or more
                    chk(sol_o == (prev_gap > 8), "R3", "sol at frame head", int'(sol_o),
                        int'(prev_gap > 8));
                    // R5 / R6 frame opened only after more than 510 low clocks
                    chk(sof_o == bnd, (prev_gap > 1000) ? "R6" : "R5", "sof at frame head",
                        int'(sof_o), int'(bnd));
                    // R7 / R8 results reported only when armed
                    chk(frame_done_o == (bnd && armed), armed ? "R7" : "R8", "frame_done",
                        int'(frame_done_o), int'(bnd && armed));
                    if (bnd && armed) begin
                        chk(frame_lines_o == LINE_CW'(acc_lines), "R7", "frame lines",
                            int'(frame_lines_o), acc_lines);
                        chk(frame_width_o == PIX_CW'(acc_w), "R7", "widest line",
                            int'(frame_width_o), acc_w);
                        chk(ratio_o == RATIO_W'(pend_r), (pend_r != 0) ? "R9" : "R10",
                            "ratio", int'(ratio_o), pend_r);
                        chk(fmt_valid_o == (pend_r != 0) && fmt_invalid_o == (pend_r == 0),
                            (pend_r != 0) ? "R9" : "R10", "valid flag", int'(fmt_valid_o),
                            int'(pend_r != 0));
                        chk(wide_o == (acc_w > MAXW), "R11", "wide warning", int'(wide_o),
                            int'(acc_w > MAXW));
                        last_lines   = acc_lines;
                        have_latched = 1'b1;
                    end
                    if (bnd) begin
                        armed     = 1'b1;
                        acc_lines = 0;
                        acc_w     = 0;
                    end
                end else if (px == 0) begin
                    @(posedge clk);
                    #1;
                    // R3 exact nine-clock gap opens a new line
                    chk(sol_o == 1'b1 && sof_o == 1'b0, "R3", "sol inside frame",
                        int'(sol_o), 1);
                    if (have_latched) begin
                        // R12 reported count holds between reports
                        chk(frame_lines_o == LINE_CW'(last_lines), "R12", "held lines",
                            int'(frame_lines_o), last_lines);
                    end
                end else if (split != 0 && ln == 1 && px == lw / 2) begin
                    @(posedge clk);
                    #1;
                    // R4 eight-clock pause keeps the line together
                    chk(sol_o == 1'b0, "R4", "no sol after short pause", int'(sol_o), 0);
                end
            end
            if (lw > acc_w) acc_w = lw;
            if (ln < nl - 1) repeat (9) tick(1'b0, 0);
            else             repeat (vb) tick(1'b0, 0);
        end
        acc_lines += nl;
        prev_gap   = vb;
        pend_r     = exp_r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        check_idle_outputs("R1");
        rst_n = 1'b1;
        repeat (600) tick(1'b0, 0);
        prev_gap = 600;

        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
        end

        // R5 a 510-clock gap merges two six-line frames into one of twelve
        run_frame(6, 8, 0, 0, 510, 2);
        run_frame(6, 8, 0, 0, 520, 2);
        run_frame(24, 16, 0, 0, 520, 1);

        // R8 reset mid-stream: partial frame and first boundary are not reported
        @(negedge clk);
        rst_n = 1'b0;
        de_i  = 1'b0;
        pix_i = '0;
        repeat (3) @(negedge clk);
        check_idle_outputs("R1");
        rst_n = 1'b1;
        armed = 1'b0;
        have_latched = 1'b0;
        acc_lines = 0;
        acc_w = 0;
        repeat (5) tick(1'b0, 0);
        prev_gap = 5;
        run_frame(3, 4, 0, 0, 520, 0);
        run_frame(24, 16, 0, 0, 520, 1);
        run_frame(2, 2, 0, 0, 520, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule